// File: doc/BRIEF.md
# Layered Pipeline Sequencing Controller

This block schedules two processing chains that run side by side. The receive chain moves a packet from a physical-level decoder to a link-level decoder and on to a protocol-level decoder. The transmit chain moves a packet from a configuration request to a protocol-level encoder, then a link-level encoder, then a physical-level encoder. Each stage reports completion together with the packet size it produced and a buffer base address. The controller forwards that pair to the next stage and starts it when the stage is free. Packet sizes change between stages, because framing is removed or added, so every start carries the size that the stage before it reported.

Each completion report and the configuration request enter through a valid/ready stream. A report counts as taken on a rising edge where valid and ready are both high. The source must hold valid, size and address steady until that edge. Every link between stages has a small queue. Ready drops only when that queue is full, so a report is never lost: the source waits instead. On the stage side the controller uses plain start / ack / busy handshakes. A start stays high, with its size and address steady, until the stage acknowledges it. The stage must raise busy no later than the cycle after its ack.

Top module: `pipe_sequencer`

## Requirements
- R1: While reset is held (active-low, synchronous) and on the first cycle after it, every start output is low and every stream ready output is high.
- R2: A physical-decoder report taken on edge k, with the link decoder idle, raises the link-decoder start after edge k+1 carrying the reported size and address.
- R3: A link-decoder completion report starts the protocol decoder with the size and address the link decoder reported, not the earlier ones.
- R4: A configuration request taken on edge k, with the protocol encoder idle, raises the protocol-encoder start after edge k+1 carrying the request's size and address.
- R5: A protocol-encoder report starts the link encoder, and a link-encoder report starts the physical encoder. Each start carries the size and address that its upstream stage reported. The physical encoder receives an 11-bit size and a 9-bit base address.
- R6: A start stays high, with steady size and address, until an ack is sampled with it. It is low in the cycle that follows that edge.
- R7: No start rises while its stage's busy is high or in the cycle right after an ack. A waiting report issues on the first edge at which busy is low.
- R8: Each link holds up to QDEPTH waiting reports in addition to the one being started. Reports issue in arrival order. Ready is low exactly while the queue is full.
- R9: The two chains are independent: a stall anywhere in the receive chain does not change the timing of the transmit chain, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_phy_done_valid | input | 1 | Physical decoder has a finished packet |
| rx_phy_done_ready | output | 1 | Report can be taken |
| rx_phy_size | input | 11 | Size reported by the physical decoder |
| rx_phy_addr | input | 9 | Base address reported by the physical decoder |
| rx_lnk_start | output | 1 | Start the link decoder |
| rx_lnk_size | output | 11 | Size handed to the link decoder |
| rx_lnk_addr | output | 9 | Address handed to the link decoder |
| rx_lnk_ack | input | 1 | Link decoder took its start |
| rx_lnk_busy | input | 1 | Link decoder is working |
| rx_lnk_done_valid | input | 1 | Link decoder has a finished packet |
| rx_lnk_done_ready | output | 1 | Report can be taken |
| rx_lnk_done_size | input | 11 | Size after disassembly |
| rx_lnk_done_addr | input | 9 | Address after disassembly |
| rx_prt_start | output | 1 | Start the protocol decoder |
| rx_prt_size | output | 11 | Size handed to the protocol decoder |
| rx_prt_addr | output | 9 | Address handed to the protocol decoder |
| rx_prt_ack | input | 1 | Protocol decoder took its start |
| rx_prt_busy | input | 1 | Protocol decoder is working |
| tx_cfg_valid | input | 1 | New transmit configuration request |
| tx_cfg_ready | output | 1 | Request can be taken |
| tx_cfg_size | input | 11 | Size of the request |
| tx_cfg_addr | input | 9 | Address of the request |
| tx_prt_start | output | 1 | Start the protocol encoder |
| tx_prt_size | output | 11 | Size handed to the protocol encoder |
| tx_prt_addr | output | 9 | Address handed to the protocol encoder |
| tx_prt_ack | input | 1 | Protocol encoder took its start |
| tx_prt_busy | input | 1 | Protocol encoder is working |
| tx_prt_done_valid | input | 1 | Protocol encoder has a finished packet |
| tx_prt_done_ready | output | 1 | Report can be taken |
| tx_prt_done_size | input | 11 | Size from the protocol encoder |
| tx_prt_done_addr | input | 9 | Address from the protocol encoder |
| tx_lnk_start | output | 1 | Start the link encoder |
| tx_lnk_size | output | 11 | Size handed to the link encoder |
| tx_lnk_addr | output | 9 | Address handed to the link encoder |
| tx_lnk_ack | input | 1 | Link encoder took its start |
| tx_lnk_busy | input | 1 | Link encoder is working |
| tx_lnk_done_valid | input | 1 | Link encoder has a finished packet |
| tx_lnk_done_ready | output | 1 | Report can be taken |
| tx_lnk_done_size | input | 11 | Size after assembly |
| tx_lnk_done_addr | input | 9 | Address after assembly |
| tx_phy_start | output | 1 | Start the physical encoder |
| tx_phy_size | output | 11 | Size handed to the physical encoder |
| tx_phy_addr | output | 9 | Read base address for the physical encoder |
| tx_phy_ack | input | 1 | Physical encoder took its start |
| tx_phy_busy | input | 1 | Physical encoder is working |

## Verification
On an idle link, a report taken on one edge produces a start on the following edge. The start is therefore first seen two falling edges after the report was offered with ready high. The scoreboard stamps each expected start with that due cycle. In the directed runs marked exact it requires the start at precisely that cycle; elsewhere it requires the start no earlier than that cycle. Once a start is up, the monitor requires it to stay high, with unchanged size and address, on every falling edge until an ack has been sampled, and to be low on the very next falling edge. The monitor also requires that every rising start follows a cycle in which busy was low. Stage models raise busy together with their ack and later report completion with a transformed size. In this way each chain exercises its own forwarding.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  localparam int SIZE_W = 11;
  localparam int ADDR_W = 9;

  // One handoff item: what a stage reported and what the next one receives.
  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] addr;
  } seq_tok_t;
endpackage

// File: rtl/seq_tok_fifo.sv
`timescale 1ns/1ps
module seq_tok_fifo import seq_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  seq_tok_t din,
  input  logic     pop,
  output seq_tok_t dout,
  output logic     full,
  output logic     empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  seq_tok_t        mem [DEPTH];
  logic [IW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end
endmodule

// File: rtl/seq_handoff.sv
`timescale 1ns/1ps
// One link between two stages: queue the upstream reports, start the
// downstream stage when it is free, hold the start until it is acknowledged.
module seq_handoff import seq_pkg::*; #(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  seq_tok_t in_tok,
  input  logic     nxt_busy,
  input  logic     nxt_ack,
  output logic     start,
  output seq_tok_t out_tok
);
  logic     q_full, q_empty, issue;
  logic     start_q, hold_q;
  seq_tok_t head, tok_q;

  assign in_ready = !q_full;
  // hold_q gives the stage one cycle after its ack to raise busy.
  assign issue    = !q_empty && !start_q && !hold_q && !nxt_busy;

  seq_tok_fifo #(.DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid && in_ready),
    .din   (in_tok),
    .pop   (issue),
    .dout  (head),
    .full  (q_full),
    .empty (q_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      hold_q  <= 1'b0;
      tok_q   <= '0;
    end else begin
      hold_q <= start_q && nxt_ack;
      if (start_q && nxt_ack) begin
        start_q <= 1'b0;
      end else if (issue) begin
        start_q <= 1'b1;
        tok_q   <= head;
      end
    end
  end

  assign start   = start_q;
  assign out_tok = tok_q;
endmodule

// File: rtl/seq_chain.sv
`timescale 1ns/1ps
// A chain of NLINK handoff links; link g starts stage g of the chain.
module seq_chain import seq_pkg::*; #(
  parameter int NLINK = 2,
  parameter int DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic     [NLINK-1:0]  in_valid,
  output logic     [NLINK-1:0]  in_ready,
  input  seq_tok_t [NLINK-1:0]  in_tok,
  input  logic     [NLINK-1:0]  nxt_busy,
  input  logic     [NLINK-1:0]  nxt_ack,
  output logic     [NLINK-1:0]  start,
  output seq_tok_t [NLINK-1:0]  out_tok
);
  for (genvar g = 0; g < NLINK; g++) begin : g_link
    seq_handoff #(.DEPTH(DEPTH)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid[g]),
      .in_ready (in_ready[g]),
      .in_tok   (in_tok[g]),
      .nxt_busy (nxt_busy[g]),
      .nxt_ack  (nxt_ack[g]),
      .start    (start[g]),
      .out_tok  (out_tok[g])
    );
  end
endmodule

// File: rtl/pipe_sequencer.sv
`timescale 1ns/1ps
module pipe_sequencer import seq_pkg::*; #(
  parameter int QDEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_phy_done_valid,
  output logic              rx_phy_done_ready,
  input  logic [SIZE_W-1:0] rx_phy_size,
  input  logic [ADDR_W-1:0] rx_phy_addr,
  output logic              rx_lnk_start,
  output logic [SIZE_W-1:0] rx_lnk_size,
  output logic [ADDR_W-1:0] rx_lnk_addr,
  input  logic              rx_lnk_ack,
  input  logic              rx_lnk_busy,
  input  logic              rx_lnk_done_valid,
  output logic              rx_lnk_done_ready,
  input  logic [SIZE_W-1:0] rx_lnk_done_size,
  input  logic [ADDR_W-1:0] rx_lnk_done_addr,
  output logic              rx_prt_start,
  output logic [SIZE_W-1:0] rx_prt_size,
  output logic [ADDR_W-1:0] rx_prt_addr,
  input  logic              rx_prt_ack,
  input  logic              rx_prt_busy,
  input  logic              tx_cfg_valid,
  output logic              tx_cfg_ready,
  input  logic [SIZE_W-1:0] tx_cfg_size,
  input  logic [ADDR_W-1:0] tx_cfg_addr,
  output logic              tx_prt_start,
  output logic [SIZE_W-1:0] tx_prt_size,
  output logic [ADDR_W-1:0] tx_prt_addr,
  input  logic              tx_prt_ack,
  input  logic              tx_prt_busy,
  input  logic              tx_prt_done_valid,
  output logic              tx_prt_done_ready,
  input  logic [SIZE_W-1:0] tx_prt_done_size,
  input  logic [ADDR_W-1:0] tx_prt_done_addr,
  output logic              tx_lnk_start,
  output logic [SIZE_W-1:0] tx_lnk_size,
  output logic [ADDR_W-1:0] tx_lnk_addr,
  input  logic              tx_lnk_ack,
  input  logic              tx_lnk_busy,
  input  logic              tx_lnk_done_valid,
  output logic              tx_lnk_done_ready,
  input  logic [SIZE_W-1:0] tx_lnk_done_size,
  input  logic [ADDR_W-1:0] tx_lnk_done_addr,
  output logic              tx_phy_start,
  output logic [SIZE_W-1:0] tx_phy_size,
  output logic [ADDR_W-1:0] tx_phy_addr,
  input  logic              tx_phy_ack,
  input  logic              tx_phy_busy
);
  localparam int RX_LINKS = 2;
  localparam int TX_LINKS = 3;

  // Receive chain: link 0 -> link decoder, link 1 -> protocol decoder.
  logic     [RX_LINKS-1:0] rx_v, rx_r, rx_b, rx_a, rx_s;
  seq_tok_t [RX_LINKS-1:0] rx_in, rx_out;

  assign rx_v     = {rx_lnk_done_valid, rx_phy_done_valid};
  assign rx_in[0] = '{size: rx_phy_size,      addr: rx_phy_addr};
  assign rx_in[1] = '{size: rx_lnk_done_size, addr: rx_lnk_done_addr};
  assign rx_b     = {rx_prt_busy, rx_lnk_busy};
  assign rx_a     = {rx_prt_ack,  rx_lnk_ack};

  seq_chain #(.NLINK(RX_LINKS), .DEPTH(QDEPTH)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_v),
    .in_ready (rx_r),
    .in_tok   (rx_in),
    .nxt_busy (rx_b),
    .nxt_ack  (rx_a),
    .start    (rx_s),
    .out_tok  (rx_out)
  );

  assign rx_phy_done_ready = rx_r[0];
  assign rx_lnk_done_ready = rx_r[1];
  assign rx_lnk_start      = rx_s[0];
  assign rx_lnk_size       = rx_out[0].size;
  assign rx_lnk_addr       = rx_out[0].addr;
  assign rx_prt_start      = rx_s[1];
  assign rx_prt_size       = rx_out[1].size;
  assign rx_prt_addr       = rx_out[1].addr;

  // Transmit chain: link 0 -> protocol encoder, 1 -> link encoder, 2 -> physical encoder.
  logic     [TX_LINKS-1:0] tx_v, tx_r, tx_b, tx_a, tx_s;
  seq_tok_t [TX_LINKS-1:0] tx_in, tx_out;

  assign tx_v     = {tx_lnk_done_valid, tx_prt_done_valid, tx_cfg_valid};
  assign tx_in[0] = '{size: tx_cfg_size,      addr: tx_cfg_addr};
  assign tx_in[1] = '{size: tx_prt_done_size, addr: tx_prt_done_addr};
  assign tx_in[2] = '{size: tx_lnk_done_size, addr: tx_lnk_done_addr};
  assign tx_b     = {tx_phy_busy, tx_lnk_busy, tx_prt_busy};
  assign tx_a     = {tx_phy_ack,  tx_lnk_ack,  tx_prt_ack};

  seq_chain #(.NLINK(TX_LINKS), .DEPTH(QDEPTH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_v),
    .in_ready (tx_r),
    .in_tok   (tx_in),
    .nxt_busy (tx_b),
    .nxt_ack  (tx_a),
    .start    (tx_s),
    .out_tok  (tx_out)
  );

  assign tx_cfg_ready      = tx_r[0];
  assign tx_prt_done_ready = tx_r[1];
  assign tx_lnk_done_ready = tx_r[2];
  assign tx_prt_start      = tx_s[0];
  assign tx_prt_size       = tx_out[0].size;
  assign tx_prt_addr       = tx_out[0].addr;
  assign tx_lnk_start      = tx_s[1];
  assign tx_lnk_size       = tx_out[1].size;
  assign tx_lnk_addr       = tx_out[1].addr;
  assign tx_phy_start      = tx_s[2];
  assign tx_phy_size       = tx_out[2].size;
  assign tx_phy_addr       = tx_out[2].addr;
endmodule

// File: rtl/pipe_sequencer_chk.sv
`timescale 1ns/1ps
module pipe_sequencer_chk #(
  parameter int NL = 5,
  parameter int SW = 11,
  parameter int AW = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NL-1:0]  start,
  input logic [NL-1:0]  ack,
  input logic [NL-1:0]  busy,
  input logic [NL*SW-1:0] size,
  input logic [NL*AW-1:0] addr
);
  for (genvar i = 0; i < NL; i++) begin : g_chk
    // R6
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] && !ack[i] |=> start[i]);
    // R6
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] && ack[i] |=> !start[i]);
    // R6
    args_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] && !ack[i] |=> $stable(size[i*SW +: SW]) && $stable(addr[i*AW +: AW]));
    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start[i] && busy[i] |=> !start[i]);
    // R7
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] && ack[i] |=> !start[i] ##1 !start[i]);
  end
endmodule

bind pipe_sequencer pipe_sequencer_chk #(.NL(5), .SW(11), .AW(9)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start ({tx_phy_start, tx_lnk_start, tx_prt_start, rx_prt_start, rx_lnk_start}),
  .ack   ({tx_phy_ack, tx_lnk_ack, tx_prt_ack, rx_prt_ack, rx_lnk_ack}),
  .busy  ({tx_phy_busy, tx_lnk_busy, tx_prt_busy, rx_prt_busy, rx_lnk_busy}),
  .size  ({tx_phy_size, tx_lnk_size, tx_prt_size, rx_prt_size, rx_lnk_size}),
  .addr  ({tx_phy_addr, tx_lnk_addr, tx_prt_addr, rx_prt_addr, rx_lnk_addr})
);

// File: tb/pipe_sequencer_test.sv
`timescale 1ns/1ps
module pipe_sequencer_test;
  localparam int NL = 5;
  localparam int SW = 11;
  localparam int AW = 9;

  // Index map. Sources: 0 phy-dec report, 1 lnk-dec report, 2 tx config,
  // 3 prt-enc report, 4 lnk-enc report. Link j is fed by source j and
  // starts: 0 lnk-dec, 1 prt-dec, 2 prt-enc, 3 lnk-enc, 4 phy-enc.
  typedef struct { logic [SW-1:0] sz; logic [AW-1:0] ad; } tok_t;
  typedef struct { logic [SW-1:0] sz; logic [AW-1:0] ad; int due; bit strict; } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 4 ns period
  logic rst_n;

  logic [NL-1:0] dv, dr, st, ak, bz;
  logic [SW-1:0] dsz [NL];
  logic [AW-1:0] dad [NL];
  logic [SW-1:0] ssz [NL];
  logic [AW-1:0] sad [NL];

  pipe_sequencer uut (
    .clk(clk), .rst_n(rst_n),
    .rx_phy_done_valid(dv[0]), .rx_phy_done_ready(dr[0]), .rx_phy_size(dsz[0]), .rx_phy_addr(dad[0]),
    .rx_lnk_start(st[0]), .rx_lnk_size(ssz[0]), .rx_lnk_addr(sad[0]), .rx_lnk_ack(ak[0]), .rx_lnk_busy(bz[0]),
    .rx_lnk_done_valid(dv[1]), .rx_lnk_done_ready(dr[1]), .rx_lnk_done_size(dsz[1]), .rx_lnk_done_addr(dad[1]),
    .rx_prt_start(st[1]), .rx_prt_size(ssz[1]), .rx_prt_addr(sad[1]), .rx_prt_ack(ak[1]), .rx_prt_busy(bz[1]),
    .tx_cfg_valid(dv[2]), .tx_cfg_ready(dr[2]), .tx_cfg_size(dsz[2]), .tx_cfg_addr(dad[2]),
    .tx_prt_start(st[2]), .tx_prt_size(ssz[2]), .tx_prt_addr(sad[2]), .tx_prt_ack(ak[2]), .tx_prt_busy(bz[2]),
    .tx_prt_done_valid(dv[3]), .tx_prt_done_ready(dr[3]), .tx_prt_done_size(dsz[3]), .tx_prt_done_addr(dad[3]),
    .tx_lnk_start(st[3]), .tx_lnk_size(ssz[3]), .tx_lnk_addr(sad[3]), .tx_lnk_ack(ak[3]), .tx_lnk_busy(bz[3]),
    .tx_lnk_done_valid(dv[4]), .tx_lnk_done_ready(dr[4]), .tx_lnk_done_size(dsz[4]), .tx_lnk_done_addr(dad[4]),
    .tx_phy_start(st[4]), .tx_phy_size(ssz[4]), .tx_phy_addr(sad[4]), .tx_phy_ack(ak[4]), .tx_phy_busy(bz[4])
  );

  tok_t src_q [NL][$];
  exp_t exp_q [NL][$];
  int tests = 0, fails = 0, cyc = 0, wd = 0;
  bit running = 0, strict_mode = 0, done_flag = 0;
  logic [NL-1:0] hold_ack, pst, pak, pbz, rdy_seen;
  int ackwait [NL], busylen [NL], bcnt [NL], waitc [NL];
  logic [SW-1:0] rec_sz [NL], psz [NL];
  logic [AW-1:0] rec_ad [NL], pad [NL];
  int nxt [NL] = '{1, -1, 3, 4, -1};
  string tag [NL] = '{"R2", "R3", "R4", "R5", "R5"};

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic send(input int j, input int s, input int a);
    tok_t t;
    t.sz = SW'(s);
    t.ad = AW'(a);
    src_q[j].push_back(t);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // Monitor, stage models and stream sources, all on the falling edge.
  always @(negedge clk) begin
    if (running) begin
      cyc++;
      for (int i = 0; i < NL; i++) begin
        if (st[i] && !pst[i]) begin
          chk(!pbz[i], "R7", $sformatf("link%0d start rose while busy", i), 1, 0);
          if (exp_q[i].size() == 0) begin
            chk(1'b0, tag[i], $sformatf("link%0d unexpected start", i), 1, 0);
          end else begin
            exp_t e;
            e = exp_q[i].pop_front();
            chk(ssz[i] == e.sz, tag[i], $sformatf("link%0d size", i), int'(ssz[i]), int'(e.sz));
            chk(sad[i] == e.ad, tag[i], $sformatf("link%0d addr", i), int'(sad[i]), int'(e.ad));
            if (e.strict)
              chk(cyc == e.due, tag[i], $sformatf("link%0d start cycle", i), cyc, e.due);
            else
              chk(cyc >= e.due, tag[i], $sformatf("link%0d start too early", i), cyc, e.due);
          end
        end
        if (pst[i] && pak[i])
          chk(!st[i], "R6", $sformatf("link%0d start after ack", i), int'(st[i]), 0);
        if (pst[i] && !pak[i]) begin
          chk(st[i], "R6", $sformatf("link%0d start dropped early", i), int'(st[i]), 1);
          chk(ssz[i] == psz[i] && sad[i] == pad[i], "R6",
              $sformatf("link%0d args moved", i), int'(ssz[i]), int'(psz[i]));
        end
      end
      // stage models
      for (int i = 0; i < NL; i++) begin
        if (ak[i]) begin
          ak[i] = 1'b0;
        end else if (st[i] && !hold_ack[i] && waitc[i] >= ackwait[i]) begin
          ak[i] = 1'b1;
          bz[i] = 1'b1;
          bcnt[i] = busylen[i];
          rec_sz[i] = ssz[i];
          rec_ad[i] = sad[i];
        end else if (bz[i]) begin
          if (bcnt[i] == 0) begin
            bz[i] = 1'b0;
            if (nxt[i] >= 0) send(nxt[i], int'(SW'(rec_sz[i] - SW'(4))), int'(AW'(rec_ad[i] + AW'(1))));
          end else begin
            bcnt[i]--;
          end
        end
        if (st[i] && !ak[i]) waitc[i]++;
        else waitc[i] = 0;
      end
      // stream sources
      for (int j = 0; j < NL; j++) begin
        if (dv[j] && rdy_seen[j]) begin
          exp_t e;
          e.sz = dsz[j];
          e.ad = dad[j];
          e.due = cyc + 1;
          e.strict = strict_mode;
          exp_q[j].push_back(e);
          dv[j] = 1'b0;
        end
        if (!dv[j] && src_q[j].size() > 0) begin
          tok_t t;
          t = src_q[j].pop_front();
          dsz[j] = t.sz;
          dad[j] = t.ad;
          dv[j] = 1'b1;
        end
        rdy_seen[j] = dr[j];
      end
      pst = st;
      pak = ak;
      pbz = bz;
      for (int i = 0; i < NL; i++) begin
        psz[i] = ssz[i];
        pad[i] = sad[i];
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    wd++;
    if (wd == 100000 && !done_flag) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
      report();
      $finish;
    end
  end

  function automatic bit all_idle();
    if (st != '0 || ak != '0 || bz != '0 || dv != '0) return 1'b0;
    for (int i = 0; i < NL; i++)
      if (src_q[i].size() != 0 || exp_q[i].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic wait_idle;
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (all_idle()) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    dv = '0; ak = '0; bz = '0; hold_ack = '0;
    pst = '0; pak = '0; pbz = '0; rdy_seen = '0;
    for (int i = 0; i < NL; i++) begin
      dsz[i] = '0; dad[i] = '0; ackwait[i] = 0; busylen[i] = 2;
      bcnt[i] = 0; waitc[i] = 0; rec_sz[i] = '0; rec_ad[i] = '0; psz[i] = '0; pad[i] = '0;
    end
    repeat (4) @(negedge clk);
    chk(st == '0, "R1", "starts during reset", int'(st), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st == '0, "R1", "starts after reset", int'(st), 0);
    chk(dr == '1, "R1", "readies after reset", int'(dr), 31);
    running = 1'b1;

    // R2, R3: single receive packet, exact timing on idle links
    strict_mode = 1'b1;
    send(0, 100, 7);
    wait_idle();
    // R4, R5: single transmit packet through three stages
    send(2, 1052, 'h40);
    wait_idle();
    strict_mode = 1'b0;

    // R2 R4 R5: boundary sizes and addresses (0 wraps to 2044 downstream)
    send(0, 0, 511);
    send(2, 2047, 0);
    send(2, 3, 510);
    wait_idle();

    // R7: back-to-back reports while the link decoder stays busy
    busylen[0] = 8;
    send(0, 300, 1);
    send(0, 301, 2);
    send(0, 302, 3);
    wait_idle();
    busylen[0] = 2;

    // R8: link decoder never acks; queue fills and ready drops
    hold_ack[0] = 1'b1;
    send(0, 10, 10);
    send(0, 11, 11);
    send(0, 12, 12);
    send(0, 13, 13);
    repeat (12) @(negedge clk);
    chk(dr[0] == 1'b0, "R8", "ready while queue full", int'(dr[0]), 0);
    chk(dv[0] == 1'b1, "R8", "fourth report still offered", int'(dv[0]), 1);
    chk(st[0] == 1'b1, "R8", "first report held at start", int'(st[0]), 1);
    hold_ack[0] = 1'b0;
    wait_idle();

    // R9: receive chain stalled, transmit chain keeps exact timing
    hold_ack[0] = 1'b1;
    send(0, 200, 1);
    repeat (4) @(negedge clk);
    strict_mode = 1'b1;
    send(2, 64, 9);
    repeat (40) @(negedge clk);
    chk(exp_q[4].size() == 0 && st[4] == 1'b0, "R9", "tx chain finished", exp_q[4].size(), 0);
    chk(st[0] == 1'b1, "R9", "rx link still stalled", int'(st[0]), 1);
    strict_mode = 1'b0;
    hold_ack[0] = 1'b0;
    wait_idle();

    // R6: protocol encoder acks late; start must hold with steady args
    ackwait[2] = 4;
    send(2, 500, 20);
    wait_idle();
    ackwait[2] = 0;

    done_flag = 1'b1;
    report();
    $finish;
  end
endmodule